// File: doc/BRIEF.md
# Hot-Buffer Replacement Victim Selector

A small SRAM side buffer sits next to a wear-limited main cache and holds the lines that are written most often. When a new hot line must enter that buffer, this block decides where it goes. A free slot wins whenever one exists. Otherwise one of two policies picks the entry to give up. The policy is chosen at run time for each search.

In least-writes mode, the block compares the 8-bit write counts that the main cache already keeps for each line, so it needs no counters of its own. The minimum search is pipelined over a fixed number of cycles, which keeps it out of the cache access path. In not-recently-used mode, the block keeps one bit per buffer entry and updates it from access and insert notifications.

A search starts with a one-cycle pulse. The block captures the entry valid bits, the write counts and the policy. After a fixed latency it returns a one-cycle done pulse together with the chosen index and a flag that says whether that index is a free slot.

Top module: `hot_victim_select`

## Requirements
- R1: After reset, `done`, `free_found` and `victim_idx` are all zero, and every recently-used bit is clear.
- R2: `done` is a single-cycle pulse. It is high in the cycle that follows the fourth rising clock edge after the edge that accepted `start`, and low in the three cycles before.
- R3: A `start` that is sampled while a search is in progress has no effect. It produces no extra `done` and does not change the result of the running search.
- R4: If any bit of `ent_valid` is 0 (entry i is bit i), `free_found` is 1 with `done`, and `victim_idx` is the lowest index whose valid bit is 0. This holds under either policy.
- R5: With `policy_sel` = 0 (least writes) and all entries valid, `victim_idx` is an entry with the smallest write count. Entry i's count is `ent_wr_count[i*8 +: 8]`.
- R6: In least-writes mode, when several entries share the smallest count, the lowest of their indices is returned.
- R7: Write counts compare as unsigned values over their full width, from 0 to 255.
- R8: With `policy_sel` = 1 (not recently used) and all entries valid, `victim_idx` is the lowest index whose recently-used bit is clear. A `touch` pulse sets the bit of `touch_idx`.
- R9: If a `touch` would leave every recently-used bit set, all bits except the touched one are cleared instead.
- R10: A search never changes the recently-used bits. Repeating a search without touches gives the same victim.
- R11: The policy is the value of `policy_sel` at the accepted `start`. Later changes during the search are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a search |
| policy_sel | input | 1 | 0 = least writes, 1 = not recently used |
| ent_valid | input | ENTRIES | Valid bit of each buffer entry |
| ent_wr_count | input | ENTRIES*CNT_W | Write count of each entry's line, entry i at bits i*CNT_W upward |
| touch | input | 1 | Access or insert notification for one entry |
| touch_idx | input | IDX_W | Entry named by `touch` |
| done | output | 1 | Result valid pulse |
| free_found | output | 1 | The result is a free slot, not a victim |
| victim_idx | output | IDX_W | Chosen entry index, held until the next result |

## Verification
The embedded checks assume three things about the inputs. `ent_valid` and `ent_wr_count` stay unchanged from the accepted `start` through the `done` cycle. `touch` is quiet between a `start` and its `done`. `touch_idx` always names an existing entry. Under these assumptions, the check that the returned entry has the minimum count, and the check that a free result points at an invalid entry, can both read the live input ports. The directed stimulus changes only `policy_sel` and `start` while a search is running. It touches entries only between searches, and it uses indices below eight.

// File: rtl/hvs_pkg.sv
package hvs_pkg;
   typedef enum logic {
      POL_LEAST_WR = 1'b0,
      POL_NRU      = 1'b1
   } hvs_policy_e;
endpackage

// File: rtl/hvs_min_tree.sv
module hvs_min_tree #(
   parameter int ENTRIES = 8,
   parameter int CNT_W   = 8,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [ENTRIES*CNT_W-1:0] counts_flat,
   output logic [IDX_W-1:0]         min_idx
);
   // Level 0 captures the counts; each later level halves the candidates
   // and is registered, so the search spends IDX_W cycles after capture.
   genvar l;
   for (l = 0; l <= IDX_W; l++) begin : g_lvl
      localparam int NODES = ENTRIES >> l;
      logic [CNT_W-1:0] cnt [NODES];
      logic [IDX_W-1:0] idx [NODES];
      if (l == 0) begin : g_cap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int n = 0; n < NODES; n++) cnt[n] <= '0;
            end else if (load) begin
               for (int n = 0; n < NODES; n++)
                  cnt[n] <= counts_flat[n*CNT_W +: CNT_W];
            end
         end
         always_comb begin
            for (int n = 0; n < NODES; n++) idx[n] = IDX_W'(n);
         end
      end else begin : g_red
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int n = 0; n < NODES; n++) begin
                  cnt[n] <= '0;
                  idx[n] <= '0;
               end
            end else begin
               for (int n = 0; n < NODES; n++) begin
                  // right child wins only when strictly smaller: ties keep lower index
                  if (g_lvl[l-1].cnt[2*n+1] < g_lvl[l-1].cnt[2*n]) begin
                     cnt[n] <= g_lvl[l-1].cnt[2*n+1];
                     idx[n] <= g_lvl[l-1].idx[2*n+1];
                  end else begin
                     cnt[n] <= g_lvl[l-1].cnt[2*n];
                     idx[n] <= g_lvl[l-1].idx[2*n];
                  end
               end
            end
         end
      end
   end

   assign min_idx = g_lvl[IDX_W].idx[0];
endmodule

// File: rtl/hvs_nru_bits.sv
module hvs_nru_bits #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               touch,
   input  logic [IDX_W-1:0]   touch_idx,
   output logic [ENTRIES-1:0] used_bits,
   output logic [IDX_W-1:0]   pick_idx
);
   logic [ENTRIES-1:0] touch_mask;
   logic               would_fill;

   assign touch_mask = ENTRIES'(1) << touch_idx;
   assign would_fill = &(used_bits | touch_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         used_bits <= '0;
      else if (touch) begin
         if (would_fill) used_bits <= touch_mask;
         else            used_bits <= used_bits | touch_mask;
      end
   end

   always_comb begin
      pick_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--)
         if (!used_bits[i]) pick_idx = IDX_W'(i);
   end

   assert_touch_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      touch |=> used_bits[$past(touch_idx)]);

   assert_never_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(&used_bits));

   assert_quiet_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !touch |=> $stable(used_bits));
endmodule

// File: rtl/hvs_free_scan.sv
module hvs_free_scan #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] valid,
   output logic               any_free,
   output logic [IDX_W-1:0]   free_idx
);
   always_comb begin
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--)
         if (!valid[i]) free_idx = IDX_W'(i);
   end
   assign any_free = ~&valid;
endmodule

// File: rtl/hot_victim_select.sv
module hot_victim_select
   import hvs_pkg::*;
#(
   parameter int ENTRIES    = 8,
   parameter int CNT_W      = 8,
   parameter int SEARCH_LAT = 4,
   parameter int IDX_W      = $clog2(ENTRIES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     policy_sel,
   input  logic [ENTRIES-1:0]       ent_valid,
   input  logic [ENTRIES*CNT_W-1:0] ent_wr_count,
   input  logic                     touch,
   input  logic [IDX_W-1:0]         touch_idx,
   output logic                     done,
   output logic                     free_found,
   output logic [IDX_W-1:0]         victim_idx
);
   localparam int LAT_CW = $clog2(SEARCH_LAT + 1);

   initial begin
      assert_entries_pow2: assert (ENTRIES >= 2 && (ENTRIES & (ENTRIES - 1)) == 0);
      assert_latency_fits: assert (SEARCH_LAT >= IDX_W + 1);
      assert_count_width:  assert (CNT_W >= 1);
   end

   logic [SEARCH_LAT-1:0] pend_q;
   logic                  busy, accept;
   logic [ENTRIES-1:0]    valid_cap;
   hvs_policy_e           pol_cap;
   logic [IDX_W-1:0]      tree_idx, nru_idx, free_idx;
   logic [ENTRIES-1:0]    used_bits;
   logic                  any_free;

   assign busy   = |pend_q;
   assign accept = start & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= '0;
         valid_cap <= '1;
         pol_cap   <= POL_LEAST_WR;
      end else begin
         pend_q <= {pend_q[SEARCH_LAT-2:0], accept};
         if (accept) begin
            valid_cap <= ent_valid;
            pol_cap   <= hvs_policy_e'(policy_sel);
         end
      end
   end

   hvs_min_tree #(.ENTRIES(ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_tree (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .counts_flat(ent_wr_count), .min_idx(tree_idx));

   hvs_nru_bits #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_nru (
      .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx),
      .used_bits(used_bits), .pick_idx(nru_idx));

   hvs_free_scan #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_free (
      .valid(valid_cap), .any_free(any_free), .free_idx(free_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done       <= 1'b0;
         free_found <= 1'b0;
         victim_idx <= '0;
      end else begin
         done <= pend_q[SEARCH_LAT-1];
         if (pend_q[SEARCH_LAT-1]) begin
            free_found <= any_free;
            if (any_free)                victim_idx <= free_idx;
            else if (pol_cap == POL_NRU) victim_idx <= nru_idx;
            else                         victim_idx <= tree_idx;
         end
      end
   end

   // cycles since the last accepted start, saturating; used only by checks
   logic [LAT_CW-1:0] since_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              since_q <= LAT_CW'(SEARCH_LAT);
      else if (accept)                         since_q <= '0;
      else if (since_q != LAT_CW'(SEARCH_LAT)) since_q <= since_q + 1'b1;
   end

   assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> since_q == LAT_CW'(SEARCH_LAT));

   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> $stable(valid_cap) && $stable(pol_cap));

   assert_free_is_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && free_found) |-> !ent_valid[victim_idx]);

   always @(negedge clk) begin
      if (rst_n && done && !free_found && pol_cap == POL_LEAST_WR) begin
         for (int i = 0; i < ENTRIES; i++) begin
            assert_lw_minimum_R5: assert (ent_wr_count[victim_idx*CNT_W +: CNT_W]
                                          <= ent_wr_count[i*CNT_W +: CNT_W]);
         end
      end
   end
endmodule

// File: tb/tb_hot_victim_select.sv
module tb_hot_victim_select;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        policy_sel = 1'b0;
   logic [7:0]  ent_valid = 8'hFF;
   logic [63:0] ent_wr_count = '0;
   logic        touch = 1'b0;
   logic [2:0]  touch_idx = '0;
   logic        done, free_found;
   logic [2:0]  victim_idx;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   hot_victim_select dut (
      .clk(clk), .rst_n(rst_n), .start(start), .policy_sel(policy_sel),
      .ent_valid(ent_valid), .ent_wr_count(ent_wr_count),
      .touch(touch), .touch_idx(touch_idx),
      .done(done), .free_found(free_found), .victim_idx(victim_idx));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_touch(input int idx);
      @(negedge clk);
      touch = 1'b1;
      touch_idx = 3'(idx);
      @(negedge clk);
      touch = 1'b0;
   endtask

   // Drives one search, checks the R2 timing and returns the result.
   task automatic search(input bit pol, input logic [7:0] val, input logic [63:0] cnt,
                         input bit flip_pol, input bit extra_start,
                         output int idx, output int fr);
      int early = 0;
      @(negedge clk);
      policy_sel = pol;
      ent_valid = val;
      ent_wr_count = cnt;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int k = 1; k <= 3; k++) begin
         if (k == 1 && flip_pol) policy_sel = ~pol;
         if (k == 1 && extra_start) start = 1'b1;
         @(posedge clk);
         #1;
         start = 1'b0;
         if (done) early++;
      end
      chk("R2 done early", early, 0);
      @(posedge clk);
      #1;
      chk("R2 done at fourth edge", int'(done), 1);
      idx = int'(victim_idx);
      fr = int'(free_found);
      @(posedge clk);
      #1;
      chk("R2 done single pulse", int'(done), 0);
      policy_sel = pol;
   endtask

   localparam logic [63:0] CNT_A = {8'd40, 8'd15, 8'd200, 8'd77, 8'd12, 8'd90, 8'd30, 8'd50};

   task automatic t_reset;
      chk("R1 done after reset", int'(done), 0);
      chk("R1 free after reset", int'(free_found), 0);
      chk("R1 victim after reset", int'(victim_idx), 0);
   endtask

   task automatic t_least_writes;
      int idx, fr;
      search(1'b0, 8'hFF, CNT_A, 0, 0, idx, fr);
      chk("R5 minimum count", idx, 3);
      chk("R5 no free slot", fr, 0);
      search(1'b0, 8'hFF, {8'd100, 8'd3, 8'd100, 8'd3, 8'd100, 8'd100, 8'd100, 8'd100}, 0, 0, idx, fr);
      chk("R5 minimum count second pattern", idx, 4);
   endtask

   task automatic t_ties;
      int idx, fr;
      search(1'b0, 8'hFF, {8'd11, 8'd5, 8'd9, 8'd6, 8'd8, 8'd5, 8'd7, 8'd9}, 0, 0, idx, fr);
      chk("R6 tie lowest index", idx, 2);
      search(1'b0, 8'hFF, {8{8'd100}}, 0, 0, idx, fr);
      chk("R6 all equal", idx, 0);
      search(1'b0, 8'hFF, {8'd3, 8'd10, 8'd3, 8'd10, 8'd10, 8'd10, 8'd10, 8'd10}, 0, 0, idx, fr);
      chk("R6 tie in upper half", idx, 5);
   endtask

   task automatic t_unsigned;
      int idx, fr;
      search(1'b0, 8'hFF, {8'd0, {7{8'd255}}}, 0, 0, idx, fr);
      chk("R7 zero against saturated", idx, 7);
      search(1'b0, 8'hFF, {8'd200, 8'd200, 8'd200, 8'd127, 8'd200, 8'd200, 8'd128, 8'd200}, 0, 0, idx, fr);
      chk("R7 unsigned compare 127 vs 128", idx, 4);
   endtask

   task automatic t_free;
      int idx, fr;
      search(1'b0, 8'b1111_0101, CNT_A, 0, 0, idx, fr);
      chk("R4 free flag least writes", fr, 1);
      chk("R4 free index least writes", idx, 1);
      search(1'b1, 8'b1111_0101, CNT_A, 0, 0, idx, fr);
      chk("R4 free flag nru", fr, 1);
      chk("R4 free index nru", idx, 1);
      search(1'b1, 8'b0111_1111, CNT_A, 0, 0, idx, fr);
      chk("R4 last entry free", idx, 7);
   endtask

   task automatic t_nru;
      int idx, fr;
      search(1'b1, 8'hFF, CNT_A, 0, 0, idx, fr);
      chk("R1 nru bits clear after reset", idx, 0);
      chk("R8 nru no free slot", fr, 0);
      do_touch(0); do_touch(1); do_touch(2);
      search(1'b1, 8'hFF, CNT_A, 0, 0, idx, fr);
      chk("R8 first clear bit", idx, 3);
      search(1'b1, 8'hFF, CNT_A, 0, 0, idx, fr);
      chk("R10 repeat search same victim", idx, 3);
      do_touch(5); do_touch(3);
      search(1'b1, 8'hFF, CNT_A, 0, 0, idx, fr);
      chk("R8 skip touched entries", idx, 4);
      do_touch(4); do_touch(6);
      search(1'b1, 8'hFF, CNT_A, 0, 0, idx, fr);
      chk("R8 only top bit clear", idx, 7);
      do_touch(7);
      search(1'b1, 8'hFF, CNT_A, 0, 0, idx, fr);
      chk("R9 clear all but touched", idx, 0);
      do_touch(7);
      search(1'b1, 8'hFF, CNT_A, 0, 0, idx, fr);
      chk("R9 retouch keeps others clear", idx, 0);
      do_touch(0);
      search(1'b1, 8'hFF, CNT_A, 0, 0, idx, fr);
      chk("R8 after clear cycle", idx, 1);
   endtask

   task automatic t_busy_start;
      int idx, fr, extra = 0;
      search(1'b0, 8'hFF, CNT_A, 0, 1, idx, fr);
      chk("R3 result of first search kept", idx, 3);
      for (int k = 0; k < 6; k++) begin
         @(posedge clk);
         #1;
         if (done) extra++;
      end
      chk("R3 no extra done", extra, 0);
   endtask

   task automatic t_policy_capture;
      int idx, fr;
      // used bits now hold entries 0 and 7: nru answer 1, least-writes answer 3
      search(1'b0, 8'hFF, CNT_A, 1, 0, idx, fr);
      chk("R11 least writes kept after flip", idx, 3);
      search(1'b1, 8'hFF, CNT_A, 1, 0, idx, fr);
      chk("R11 nru kept after flip", idx, 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      t_reset();
      t_least_writes();
      t_ties();
      t_unsigned();
      t_free();
      t_nru();
      t_busy_start();
      t_policy_capture();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule